// File: doc/BRIEF.md
# Watchdog Timer with Shared Scaler

This block is a watchdog timer. It counts pulses from its own free-running tick source, which is separate from the core clock. Because the tick source keeps pulsing while the core sleeps, the watchdog keeps counting during sleep. An 8-bit scaler is shared between the watchdog and a neighbouring general-purpose timer. An ownership bit decides which of the two feeds the scaler. A 3-bit select field picks one of eight divide ratios, the powers of two from 1 to 128.

A base counter sets the shortest period, `BASE_TICKS` ticks. When the scaler belongs to the watchdog, the period grows by the selected ratio. At expiry the block does one of two things. If the core is awake, it pulses a reset request. If the core is asleep, it pulses a wake-up request. In both cases it drives the active-low time-out flag to 0. Software keeps the block from expiring by issuing the clear strobe, or by issuing the sleep strobe on the way into sleep. Both strobes restart the count and set the flag back to 1. When the scaler belongs to the timer, the block passes the divided timer increments out to that timer.

Top module: `wdt_prescaled`

## Requirements
- R1: With the ownership bit `opt_psa_i` at 0, the watchdog expires on the `BASE_TICKS`-th tick after a restart, whatever the value of `opt_ps_i`.
- R2: With `opt_psa_i` at 1 and select code p on `opt_ps_i` (0 to 7), the watchdog expires on tick number `BASE_TICKS * 2^p` after a restart.
- R3: An expiry while `asleep_i` is 0 drives `wdt_rst_req_o` high for exactly one cycle. The pulse is registered at the clock edge that samples the final tick, and `wdt_wake_req_o` stays 0.
- R4: An expiry while `asleep_i` is 1 drives `wdt_wake_req_o` high for exactly one cycle, with the same timing as R3, and `wdt_rst_req_o` stays 0.
- R5: `to_n_o` goes to 0 at the same edge as an expiry pulse. It returns to 1 at the edge that samples `clrwdt_i` or `sleep_i`.
- R6: While `cfg_wdt_en_i` is 0, neither request ever pulses and `to_n_o` keeps its value.
- R7: A `clrwdt_i` or `sleep_i` strobe restarts the base count. It also restarts the scaler when the scaler belongs to the watchdog. A strobe in the same cycle as the final tick suppresses that expiry.
- R8: A `clrwdt_i` strobe leaves the ownership unchanged. When the timer owns the scaler, the strobe does not disturb the scaler count.
- R9: The option inputs are registered. Any change to them clears the scaler, and the new values take effect one cycle later. No stale partial count shortens the next period.
- R10: With `opt_psa_i` at 0, `tmr_inc_o` pulses, in the same cycle, on every 2^p-th `tmr_tick_i` pulse. With `opt_psa_i` at 1, `tmr_inc_o` follows `tmr_tick_i` directly.
- R11: After reset, both request outputs and `tmr_inc_o` are 0 and `to_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock in which the tick strobes are sampled |
| rst_n | input | 1 | Asynchronous reset, active low |
| wdt_tick_i | input | 1 | One-cycle pulse from the watchdog's own tick source |
| tmr_tick_i | input | 1 | Increment source of the general-purpose timer |
| cfg_wdt_en_i | input | 1 | Configuration enable; 0 disables the watchdog |
| opt_psa_i | input | 1 | Scaler ownership: 1 for the watchdog, 0 for the timer |
| opt_ps_i | input | 3 | Scaler tap select; the ratio is 2^code |
| clrwdt_i | input | 1 | Clear-watchdog strobe |
| sleep_i | input | 1 | Sleep-command strobe |
| asleep_i | input | 1 | Level input, 1 while the core is asleep |
| wdt_rst_req_o | output | 1 | One-cycle reset request |
| wdt_wake_req_o | output | 1 | One-cycle wake-up request |
| to_n_o | output | 1 | Time-out flag, 0 after an expiry |
| tmr_inc_o | output | 1 | Increment pulse handed to the timer |

## Verification
The request pulses and the flag are registered. Each one is due at the edge that samples the final tick, so the bench raises a tick on a falling edge and reads the outputs on the next falling edge. The bench then checks that the pulse has ended one cycle later. `tmr_inc_o` is combinational, so the bench reads it shortly after driving `tmr_tick_i`, before the next edge. An option change takes one edge to register and clear the scaler, so the bench lets two idle cycles pass after each change before it counts ticks.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam int unsigned SEL_W = 3;

   typedef struct packed {
      logic             psa;
      logic [SEL_W-1:0] ps;
   } wdt_opt_t;

   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_RESET = 2'd1,
      ACT_WAKE  = 2'd2
   } wdt_act_e;

   localparam wdt_opt_t OPT_RESET_VAL = '{psa: 1'b1, ps: '1};

endpackage

// File: rtl/wdt_base_cnt.sv
module wdt_base_cnt #(
   parameter int unsigned BASE_TICKS = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic run_i,
   input  logic clear_i,
   output logic wrap_o
);
   localparam int unsigned CW = (BASE_TICKS < 2) ? 1 : $clog2(BASE_TICKS);
   localparam logic [CW-1:0] LAST = CW'(BASE_TICKS - 1);
   localparam bit POW2 = ((1 << CW) == BASE_TICKS);

   if (BASE_TICKS < 2) begin : g_bad_base
      $error("wdt_base_cnt: BASE_TICKS must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_inc;
   logic          at_last;

   assign at_last = (cnt_q == LAST);
   assign wrap_o  = run_i & tick_i & at_last & ~clear_i;

   if (POW2) begin : g_wrap_natural
      assign cnt_inc = cnt_q + 1'b1;
   end else begin : g_wrap_compare
      assign cnt_inc = at_last ? '0 : cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i || !run_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= cnt_inc;
      end
   end

endmodule

// File: rtl/wdt_scaler.sv
module wdt_scaler #(
   parameter int unsigned SCALER_W = 8,
   parameter int unsigned SEL_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_i,
   input  logic             clear_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             pulse_o
);
   localparam int unsigned TAPS = 1 << SEL_W;

   if (TAPS > SCALER_W) begin : g_bad_taps
      $error("wdt_scaler: select field reaches past the scaler width");
   end

   logic [SCALER_W-1:0] cnt_q;
   logic [SCALER_W-1:0] mask;

   for (genvar i = 0; i < SCALER_W; i++) begin : g_mask
      assign mask[i] = (int'(sel_i) > i);
   end

   assign pulse_o = src_i & ~clear_i & ((cnt_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear_i) begin
         cnt_q <= '0;
      end else if (src_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/wdt_tout_ctrl.sv
module wdt_tout_ctrl
   import wdt_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic expire_i,
   input  logic en_i,
   input  logic clear_i,
   input  logic asleep_i,
   output logic rst_req_o,
   output logic wake_req_o,
   output logic to_n_o
);
   wdt_act_e act;
   logic     fire;

   assign fire = expire_i & en_i & ~clear_i;

   always_comb begin
      act = ACT_NONE;
      if (fire) begin
         act = asleep_i ? ACT_WAKE : ACT_RESET;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req_o  <= 1'b0;
         wake_req_o <= 1'b0;
         to_n_o     <= 1'b1;
      end else begin
         rst_req_o  <= (act == ACT_RESET);
         wake_req_o <= (act == ACT_WAKE);
         if (clear_i) begin
            to_n_o <= 1'b1;
         end else if (fire) begin
            to_n_o <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/wdt_prescaled.sv
module wdt_prescaled
   import wdt_pkg::*;
#(
   parameter int unsigned BASE_TICKS = 256,
   parameter int unsigned SCALER_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wdt_tick_i,
   input  logic             tmr_tick_i,
   input  logic             cfg_wdt_en_i,
   input  logic             opt_psa_i,
   input  logic [SEL_W-1:0] opt_ps_i,
   input  logic             clrwdt_i,
   input  logic             sleep_i,
   input  logic             asleep_i,
   output logic             wdt_rst_req_o,
   output logic             wdt_wake_req_o,
   output logic             to_n_o,
   output logic             tmr_inc_o
);
   if (SCALER_W < (1 << SEL_W)) begin : g_bad_width
      $error("wdt_prescaled: SCALER_W too small for the select field");
   end

   wdt_opt_t opt_in;
   wdt_opt_t opt_q;
   logic     opt_chg;
   logic     kill;
   logic     base_wrap;
   logic     sc_src;
   logic     sc_clear;
   logic     sc_pulse;
   logic     expire;

   assign opt_in  = '{psa: opt_psa_i, ps: opt_ps_i};
   assign opt_chg = (opt_in != opt_q);
   assign kill    = clrwdt_i | sleep_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opt_q <= OPT_RESET_VAL;
      end else begin
         opt_q <= opt_in;
      end
   end

   wdt_base_cnt #(
      .BASE_TICKS (BASE_TICKS)
   ) i_base (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (wdt_tick_i),
      .run_i   (cfg_wdt_en_i),
      .clear_i (kill),
      .wrap_o  (base_wrap)
   );

   assign sc_src   = opt_q.psa ? base_wrap : tmr_tick_i;
   assign sc_clear = opt_chg | (kill & opt_q.psa);

   wdt_scaler #(
      .SCALER_W (SCALER_W),
      .SEL_W    (SEL_W)
   ) i_scaler (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_i   (sc_src),
      .clear_i (sc_clear),
      .sel_i   (opt_q.ps),
      .pulse_o (sc_pulse)
   );

   assign expire    = opt_q.psa ? sc_pulse : base_wrap;
   assign tmr_inc_o = opt_q.psa ? tmr_tick_i : sc_pulse;

   wdt_tout_ctrl i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .expire_i   (expire),
      .en_i       (cfg_wdt_en_i),
      .clear_i    (kill),
      .asleep_i   (asleep_i),
      .rst_req_o  (wdt_rst_req_o),
      .wake_req_o (wdt_wake_req_o),
      .to_n_o     (to_n_o)
   );

endmodule

// File: rtl/wdt_prescaled_chk.sv
module wdt_prescaled_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_wdt_en_i,
   input logic clrwdt_i,
   input logic sleep_i,
   input logic asleep_i,
   input logic wdt_rst_req_o,
   input logic wdt_wake_req_o,
   input logic to_n_o
);
   // R3
   rst_pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_req_o |=> !wdt_rst_req_o);

   // R4
   wake_pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_wake_req_o |=> !wdt_wake_req_o);

   // R4
   req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wdt_rst_req_o && wdt_wake_req_o));

   // R4
   wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_wake_req_o) |-> $past(asleep_i));

   // R5
   flag_falls_with_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(to_n_o) |-> (wdt_rst_req_o || wdt_wake_req_o));

   // R7
   strobe_restores_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clrwdt_i || sleep_i) |=> (to_n_o && !wdt_rst_req_o && !wdt_wake_req_o));

   // R6
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wdt_en_i |=> (!wdt_rst_req_o && !wdt_wake_req_o));

endmodule

bind wdt_prescaled wdt_prescaled_chk i_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_wdt_en_i   (cfg_wdt_en_i),
   .clrwdt_i       (clrwdt_i),
   .sleep_i        (sleep_i),
   .asleep_i       (asleep_i),
   .wdt_rst_req_o  (wdt_rst_req_o),
   .wdt_wake_req_o (wdt_wake_req_o),
   .to_n_o         (to_n_o)
);

// File: tb/test_wdt_prescaled.sv
module test_wdt_prescaled;
   localparam int BASE = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wdt_tick = 1'b0;
   logic       tmr_tick = 1'b0;
   logic       cfg_en = 1'b1;
   logic       psa = 1'b1;
   logic [2:0] ps = 3'd0;
   logic       clr = 1'b0;
   logic       slp = 1'b0;
   logic       asleep = 1'b0;
   logic       rst_req, wake_req, to_n, tmr_inc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   wdt_prescaled #(.BASE_TICKS(BASE), .SCALER_W(8)) i_wdt_prescaled (
      .clk(clk), .rst_n(rst_n), .wdt_tick_i(wdt_tick), .tmr_tick_i(tmr_tick),
      .cfg_wdt_en_i(cfg_en), .opt_psa_i(psa), .opt_ps_i(ps), .clrwdt_i(clr),
      .sleep_i(slp), .asleep_i(asleep), .wdt_rst_req_o(rst_req),
      .wdt_wake_req_o(wake_req), .to_n_o(to_n), .tmr_inc_o(tmr_inc));

   // {psa, ps[2:0], asleep, en, expected tick count[9:0]}; 0 means none
   localparam logic [15:0] VEC [8] = '{
      {1'b0, 3'd0, 1'b0, 1'b1, 10'd4},
      {1'b1, 3'd0, 1'b0, 1'b1, 10'd4},
      {1'b1, 3'd1, 1'b0, 1'b1, 10'd8},
      {1'b1, 3'd3, 1'b1, 1'b1, 10'd32},
      {1'b1, 3'd7, 1'b0, 1'b1, 10'd512},
      {1'b0, 3'd5, 1'b1, 1'b1, 10'd4},
      {1'b1, 3'd2, 1'b0, 1'b0, 10'd0},
      {1'b1, 3'd2, 1'b1, 1'b1, 10'd16}
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic strobe_clr();
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
   endtask

   task automatic set_opt(input logic p, input logic [2:0] s);
      @(negedge clk);
      psa = p;
      ps  = s;
      idle(2);
   endtask

   // one tick; returns 0 none, 1 reset request, 2 wake request
   task automatic tick(output int kind);
      @(negedge clk) wdt_tick = 1'b1;
      @(negedge clk) wdt_tick = 1'b0;
      kind = rst_req ? 1 : (wake_req ? 2 : 0);
   endtask

   // ticks until first request or limit; returns tick number (0 if none)
   task automatic run_ticks(input int limit, output int at, output int kind);
      int k;
      at = 0;
      kind = 0;
      for (int n = 1; n <= limit; n++) begin
         tick(k);
         if (k != 0) begin
            at = n;
            kind = k;
            break;
         end
      end
   endtask

   task automatic tmr_pulse(output int v);
      @(negedge clk) tmr_tick = 1'b1;
      #1 v = int'(tmr_inc);
      @(negedge clk) tmr_tick = 1'b0;
   endtask

   initial begin
      int at, kind, v;
      idle(3);
      // R11 reset state
      check("R11 rst_req", int'(rst_req), 0);
      check("R11 wake_req", int'(wake_req), 0);
      check("R11 to_n", int'(to_n), 1);
      check("R11 tmr_inc", int'(tmr_inc), 0);
      @(negedge clk) rst_n = 1'b1;
      idle(2);

      // table walk: R1 R2 R3 R4 R5 R6
      foreach (VEC[i]) begin
         logic [15:0] e;
         int expn, expk;
         e = VEC[i];
         @(negedge clk);
         cfg_en = e[10];
         asleep = e[11];
         set_opt(e[15], e[14:12]);
         strobe_clr();
         expn = int'(e[9:0]);
         expk = (expn == 0) ? 0 : (e[11] ? 2 : 1);
         run_ticks((expn == 0) ? 16 : expn, at, kind);
         check(e[15] ? "R2 expiry tick" : "R1 expiry tick", at, expn);
         check(e[11] ? "R4 request kind" : "R3 request kind", kind, expk);
         check(expn == 0 ? "R6 flag kept" : "R5 flag low", int'(to_n), expn == 0 ? 1 : 0);
         @(negedge clk);
         check("R3 pulse width", int'(rst_req | wake_req), 0);
      end
      cfg_en = 1'b1;
      asleep = 1'b0;

      // R5 clear strobe restores the flag
      strobe_clr();
      check("R5 flag after clear", int'(to_n), 1);

      // R7 sleep strobe restarts count and restores flag
      set_opt(1'b0, 3'd0);
      run_ticks(4, at, kind);
      check("R5 flag low before sleep", int'(to_n), 0);
      run_ticks(3, at, kind);
      @(negedge clk) slp = 1'b1;
      @(negedge clk) slp = 1'b0;
      check("R5 flag after sleep", int'(to_n), 1);
      run_ticks(4, at, kind);
      check("R7 restart after sleep", at, 4);

      // R7 clear in the same cycle as final tick suppresses expiry
      strobe_clr();
      run_ticks(3, at, kind);
      @(negedge clk) begin wdt_tick = 1'b1; clr = 1'b1; end
      @(negedge clk) begin wdt_tick = 1'b0; clr = 1'b0; end
      check("R7 suppressed request", int'(rst_req), 0);
      check("R7 suppressed flag", int'(to_n), 1);
      run_ticks(4, at, kind);
      check("R7 restart after clash", at, 4);

      // R8 clear keeps ownership and clears watchdog-owned scaler
      set_opt(1'b1, 3'd1);
      strobe_clr();
      run_ticks(5, at, kind);
      strobe_clr();
      run_ticks(8, at, kind);
      check("R8 full period after clear", at, 8);

      // R9 option change clears scaler
      strobe_clr();
      run_ticks(4, at, kind);
      set_opt(1'b1, 3'd2);
      run_ticks(16, at, kind);
      check("R9 no early expiry", at, 16);

      // R10 timer path, scaler owned by timer
      cfg_en = 1'b0;
      set_opt(1'b0, 3'd2);
      for (int n = 1; n <= 4; n++) begin
         tmr_pulse(v);
         check("R10 divided increment", v, (n == 4) ? 1 : 0);
      end
      // R8 clear does not disturb timer-owned scaler
      tmr_pulse(v);
      tmr_pulse(v);
      strobe_clr();
      tmr_pulse(v);
      check("R8 timer count kept", v, 0);
      tmr_pulse(v);
      check("R8 timer count kept", v, 1);
      // R10 scaler owned by watchdog: increment follows tick
      set_opt(1'b1, 3'd3);
      tmr_pulse(v);
      check("R10 direct increment", v, 1);
      idle(1);
      check("R10 idle increment", int'(tmr_inc), 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule